// File: doc/BRIEF.md
# Segmented Cartridge Address Translator

This block turns an access inside a 4 KB cartridge window into a physical address for one of two memories. The memories are a 128 KB ROM image and a 32 KB RAM. The window is split into four segments of unequal size:

- a 2 KB low segment;
- a 1.5 KB middle segment;
- a 256-byte high segment;
- a 256-byte fixed segment at the top.

The low, middle and high segments each have their own source flag and slice base. A separate controller supplies these, so each of those segments can show a slice of ROM or a slice of RAM. The fixed segment always shows the last page of the ROM image.

The translation is purely combinational. In the same cycle, a window address and an access strobe produce:

- a ROM address and a ROM read select;
- or a RAM address, a RAM select and a RAM write enable.

A write aimed at ROM, or at the fixed segment, leaves every select low, so nothing is stored. ROM images smaller than 128 KB are mirrored by masking the ROM address down to the image size, which is set by a parameter. The memory arrays, and the logic that changes slices, live outside this block.

Top module: `cart_seg_xlate`

## Requirements
- R1: The window page (bits 11:8 of `win_addr`) selects the segment: pages 0x0–0x7 are low, 0x8–0xD are middle, 0xE is high and 0xF is fixed.
- R2: A read in the fixed segment selects ROM at 0x1FF00 + `win_addr[7:0]`. Such a read never selects RAM. A write there raises no select and no write enable.
- R3: A read in the low segment in ROM mode gives ROM address `lo_slice` × 0x800 + `win_addr[10:0]`. This lies in the lower 64 KB.
- R4: A read in the middle segment in ROM mode gives ROM address 0x10000 + `mid_slice` × 0x800 + `win_addr[10:0]`.
- R5: A read in the high segment in ROM mode gives ROM address 0x10000 + `hi_page` × 0x100 + `win_addr[7:0]`.
- R6: In RAM mode, the low segment addresses RAM at `lo_slice[3:0]` × 0x800 + `win_addr[10:0]`. The middle segment does the same with `mid_slice[3:0]`. The high segment addresses `hi_page[6:0]` × 0x100 + `win_addr[7:0]`. There is no 0x10000 bias, and the top slice bit is ignored.
- R7: With `acc_en` high, the outputs depend on the target:
  - A read of a ROM-mode segment raises `rom_sel` only.
  - Any access to a RAM-mode segment raises `ram_sel`.
  - `ram_we` is raised only for a write to a RAM-mode segment.
  - A write to a ROM-mode segment raises nothing.
  - `rom_sel` and `ram_sel` are never high together.
- R8: With `acc_en` low, `rom_sel`, `ram_sel` and `ram_we` are all 0.
- R9: `rom_addr` is 0 whenever `rom_sel` is 0, and `ram_addr` is 0 whenever `ram_sel` is 0.
- R10: ROM address bits at and above bit `IMG_AW` are forced to 0, which mirrors a 32 KB or 64 KB image.
- R11: Every output follows its inputs within the same cycle; there is no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_en | input | 1 | Access strobe for the current cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| win_addr | input | 12 | Address relative to the window |
| lo_is_rom | input | 1 | Low segment source: 1 = ROM, 0 = RAM |
| lo_slice | input | 5 | Low segment 2 KB slice index |
| mid_is_rom | input | 1 | Middle segment source: 1 = ROM, 0 = RAM |
| mid_slice | input | 5 | Middle segment 2 KB slice index |
| hi_is_rom | input | 1 | High segment source: 1 = ROM, 0 = RAM |
| hi_page | input | 8 | High segment 256-byte page index |
| rom_sel | output | 1 | ROM read select |
| rom_addr | output | 17 | Physical ROM address, folded to the image size |
| ram_sel | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 15 | Physical RAM address |

## Verification
The block holds no state, so a fault in a segment's decode or slice path shows up at the ports in the very cycle that segment is addressed. Typical symptoms are a ROM address off by a slice or by the 0x10000 bias, a select pointing at the wrong memory, or a write enable raised on ROM. Each fault stays hidden until an access falls in the faulty segment in the faulty mode. For that reason, every page boundary is driven in both source modes and for both directions, with slice values whose top bit is set. Random accesses then cover the mixed-mode cases. A second instance with a 32 KB image is compared on every cycle to expose folding faults.

// File: rtl/cart_xlate_pkg.sv
// Package: shared constants and types for the cartridge address translator.
// Assumes a 4 KB window, a 128 KB ROM space and a 32 KB RAM.
package cart_xlate_pkg;

    localparam int WIN_AW      = 12;                  // window address bits
    localparam int ROM_AW      = 17;                  // ROM address space bits
    localparam int RAM_AW      = 15;                  // RAM address bits
    localparam int SEG_LG      = 11;                  // log2 of a 2 KB slice
    localparam int PG_LG       = 8;                   // log2 of a 256-byte page
    localparam int SEG_SLW     = ROM_AW - 1 - SEG_LG; // ROM slice index width (half space)
    localparam int PG_SLW      = ROM_AW - 1 - PG_LG;  // ROM page index width (half space)
    localparam int SEG_RAM_SLW = RAM_AW - SEG_LG;     // RAM slice index width
    localparam int PG_RAM_SLW  = RAM_AW - PG_LG;      // RAM page index width
    localparam int WPG_W       = WIN_AW - PG_LG;      // window page number width

    localparam logic [WPG_W-1:0] MID_FIRST_PG = WPG_W'(8);
    localparam logic [WPG_W-1:0] HIGH_PG      = WPG_W'(14);
    localparam logic [WPG_W-1:0] FIXED_PG     = WPG_W'(15);

    typedef enum logic [1:0] {
        SEG_LOW   = 2'd0,
        SEG_MID   = 2'd1,
        SEG_HIGH  = 2'd2,
        SEG_FIXED = 2'd3
    } seg_e;

    typedef struct packed {
        logic              is_rom;
        logic [ROM_AW-1:0] rom_a;
        logic [RAM_AW-1:0] ram_a;
    } seg_map_t;

endpackage

// File: rtl/cart_seg_decode.sv
// Module: classifies the window page number into one of four segments.
// Assumes the page layout fixed in cart_xlate_pkg; purely combinational.
module cart_seg_decode
    import cart_xlate_pkg::*;
(
    input  logic [WPG_W-1:0] win_page,
    output seg_e             seg
);

    // Priority compare from the top of the window downwards.
    always_comb begin
        if (win_page == FIXED_PG) begin
            seg = SEG_FIXED;
        end else if (win_page == HIGH_PG) begin
            seg = SEG_HIGH;
        end else if (win_page >= MID_FIRST_PG) begin
            seg = SEG_MID;
        end else begin
            seg = SEG_LOW;
        end
    end

endmodule

// File: rtl/cart_seg_map.sv
// Module: builds the ROM and RAM candidate addresses for one switchable segment.
// Assumes 1 + SLW + OFFW == ROM_AW and RAM_SLW + OFFW == RAM_AW. ROM_HI selects
// the lower or upper half of the ROM space; the RAM index drops the top slice bits.
module cart_seg_map
    import cart_xlate_pkg::*;
#(
    parameter int OFFW    = SEG_LG,
    parameter int SLW     = SEG_SLW,
    parameter int RAM_SLW = SEG_RAM_SLW,
    parameter bit ROM_HI  = 1'b0
) (
    input  logic            is_rom,
    input  logic [SLW-1:0]  slice,
    input  logic [OFFW-1:0] off,
    output seg_map_t        map
);

    localparam int ROM_W = 1 + SLW + OFFW;
    localparam int RAM_W = RAM_SLW + OFFW;

    logic [ROM_W-1:0] rom_full;
    logic [RAM_W-1:0] ram_full;

    // Concatenate half-select bit, slice and in-segment offset.
    always_comb begin
        rom_full = {ROM_HI, slice, off};
        ram_full = {slice[RAM_SLW-1:0], off};
    end

    // Pack the candidate addresses and the source flag for the segment mux.
    always_comb begin
        map.is_rom = is_rom;
        map.rom_a  = ROM_AW'(rom_full);
        map.ram_a  = RAM_AW'(ram_full);
    end

endmodule

// File: rtl/cart_rom_fold.sv
// Module: folds a ROM address to the image size so smaller images mirror.
// Assumes IMG_AW <= ROM_AW; combinational AND with a derived mask.
module cart_rom_fold
    import cart_xlate_pkg::*;
#(
    parameter int IMG_AW = ROM_AW
) (
    input  logic [ROM_AW-1:0] idx,
    output logic [ROM_AW-1:0] folded
);

    localparam logic [ROM_AW-1:0] MASK = ROM_AW'((64'd1 << IMG_AW) - 64'd1);

    // Clear every address bit above the image size.
    always_comb begin
        folded = idx & MASK;
    end

endmodule

// File: rtl/cart_seg_xlate.sv
// Top: translates a window access into a ROM read or RAM access address.
// Assumes source flags and slices are stable, driven by an outside controller.
// No state: every output is a function of the current inputs.
module cart_seg_xlate
    import cart_xlate_pkg::*;
#(
    parameter int IMG_AW = ROM_AW
) (
    input  logic                acc_en,
    input  logic                acc_wr,
    input  logic [WIN_AW-1:0]   win_addr,
    input  logic                lo_is_rom,
    input  logic [SEG_SLW-1:0]  lo_slice,
    input  logic                mid_is_rom,
    input  logic [SEG_SLW-1:0]  mid_slice,
    input  logic                hi_is_rom,
    input  logic [PG_SLW-1:0]   hi_page,
    output logic                rom_sel,
    output logic [ROM_AW-1:0]   rom_addr,
    output logic                ram_sel,
    output logic                ram_we,
    output logic [RAM_AW-1:0]   ram_addr
);

    seg_e              seg;
    seg_map_t          lo_map;
    seg_map_t          mid_map;
    seg_map_t          hi_map;
    seg_map_t          cur;
    logic [ROM_AW-1:0] fixed_rom;
    logic [ROM_AW-1:0] rom_folded;
    logic              rom_hit;
    logic              ram_hit;

    cart_seg_decode u_dec (
        .win_page (win_addr[WIN_AW-1:PG_LG]),
        .seg      (seg)
    );

    cart_seg_map #(
        .OFFW    (SEG_LG),
        .SLW     (SEG_SLW),
        .RAM_SLW (SEG_RAM_SLW),
        .ROM_HI  (1'b0)
    ) u_lo (
        .is_rom (lo_is_rom),
        .slice  (lo_slice),
        .off    (win_addr[SEG_LG-1:0]),
        .map    (lo_map)
    );

    cart_seg_map #(
        .OFFW    (SEG_LG),
        .SLW     (SEG_SLW),
        .RAM_SLW (SEG_RAM_SLW),
        .ROM_HI  (1'b1)
    ) u_mid (
        .is_rom (mid_is_rom),
        .slice  (mid_slice),
        .off    (win_addr[SEG_LG-1:0]),
        .map    (mid_map)
    );

    cart_seg_map #(
        .OFFW    (PG_LG),
        .SLW     (PG_SLW),
        .RAM_SLW (PG_RAM_SLW),
        .ROM_HI  (1'b1)
    ) u_hi (
        .is_rom (hi_is_rom),
        .slice  (hi_page),
        .off    (win_addr[PG_LG-1:0]),
        .map    (hi_map)
    );

    // Fixed segment: last page of the full ROM space.
    always_comb begin
        fixed_rom = {{(ROM_AW-PG_LG){1'b1}}, win_addr[PG_LG-1:0]};
    end

    // Pick the candidate of the addressed segment.
    always_comb begin
        case (seg)
            SEG_LOW:  cur = lo_map;
            SEG_MID:  cur = mid_map;
            SEG_HIGH: cur = hi_map;
            default:  cur = '{is_rom: 1'b1, rom_a: fixed_rom, ram_a: '0};
        endcase
    end

    cart_rom_fold #(
        .IMG_AW (IMG_AW)
    ) u_fold (
        .idx    (cur.rom_a),
        .folded (rom_folded)
    );

    // Qualify the target: ROM only on reads, RAM on reads and writes.
    always_comb begin
        rom_hit = acc_en & ~acc_wr & cur.is_rom;
        ram_hit = acc_en & ~cur.is_rom;
    end

    // Drive the outputs, with addresses held at zero when not selected.
    always_comb begin
        rom_sel  = rom_hit;
        rom_addr = rom_hit ? rom_folded : '0;
        ram_sel  = ram_hit;
        ram_we   = ram_hit & acc_wr;
        ram_addr = ram_hit ? cur.ram_a : '0;
    end

endmodule

// File: rtl/cart_seg_xlate_chk.sv
// Checker: port-level rules for cart_seg_xlate, attached with bind.
// Combinational block, so immediate assertions guarded against unknowns.
module cart_seg_xlate_chk
    import cart_xlate_pkg::*;
(
    input logic              acc_en,
    input logic              acc_wr,
    input logic [WIN_AW-1:0] win_addr,
    input logic              lo_is_rom,
    input logic              rom_sel,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              ram_sel,
    input logic              ram_we,
    input logic [RAM_AW-1:0] ram_addr
);

    // Evaluate the rules whenever the ports settle to known values.
    always_comb begin
        if (!$isunknown({acc_en, acc_wr, win_addr, lo_is_rom, rom_sel,
                         rom_addr, ram_sel, ram_we, ram_addr})) begin
            AST_SEL_EXCLUSIVE: assert (!(rom_sel && ram_sel));                            // R7
            AST_IDLE_QUIET: assert (acc_en || (!rom_sel && !ram_sel && !ram_we));          // R8
            AST_WE_NEEDS_RAM: assert (!ram_we || (ram_sel && acc_wr));                     // R7
            AST_ROM_NO_WRITE: assert (!(rom_sel && acc_wr));                               // R7
            AST_FIXED_NO_RAM: assert (win_addr[11:8] != 4'hF || (!ram_sel && !ram_we));   // R2
            AST_LOW_ROM_NO_RAM: assert (!(lo_is_rom && !win_addr[11] && ram_sel));         // R7
            AST_LOW_RAM_OFFSET: assert (!(ram_sel && !win_addr[11]) ||
                                        ram_addr[10:0] == win_addr[10:0]);                 // R6
            AST_UNSEL_ZERO: assert ((rom_sel || rom_addr == '0) &&
                                    (ram_sel || ram_addr == '0));                          // R9
        end
    end

endmodule

bind cart_seg_xlate cart_seg_xlate_chk u_chk (.*);

// File: tb/sim_cart_seg_xlate.sv
// Bench: behavioural reference model compared with two DUT instances each clock.
module sim_cart_seg_xlate;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic        acc_en, acc_wr, lo_is_rom, mid_is_rom, hi_is_rom;
    logic [11:0] win_addr;
    logic [4:0]  lo_slice, mid_slice;
    logic [7:0]  hi_page;
    logic        rom_sel, ram_sel, ram_we, rom_sel_s;
    logic [16:0] rom_addr, rom_addr_s;
    logic [14:0] ram_addr;
    logic        ram_sel_s, ram_we_s;
    logic [14:0] ram_addr_s;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    cart_seg_xlate u0 (
        .acc_en(acc_en), .acc_wr(acc_wr), .win_addr(win_addr),
        .lo_is_rom(lo_is_rom), .lo_slice(lo_slice),
        .mid_is_rom(mid_is_rom), .mid_slice(mid_slice),
        .hi_is_rom(hi_is_rom), .hi_page(hi_page),
        .rom_sel(rom_sel), .rom_addr(rom_addr),
        .ram_sel(ram_sel), .ram_we(ram_we), .ram_addr(ram_addr)
    );

    // Second instance with a 32 KB image for the folding rule.
    cart_seg_xlate #(.IMG_AW(15)) u1 (
        .acc_en(acc_en), .acc_wr(acc_wr), .win_addr(win_addr),
        .lo_is_rom(lo_is_rom), .lo_slice(lo_slice),
        .mid_is_rom(mid_is_rom), .mid_slice(mid_slice),
        .hi_is_rom(hi_is_rom), .hi_page(hi_page),
        .rom_sel(rom_sel_s), .rom_addr(rom_addr_s),
        .ram_sel(ram_sel_s), .ram_we(ram_we_s), .ram_addr(ram_addr_s)
    );

    task automatic cmp(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Reference model: compute expected outputs from the requirements and compare.
    task automatic check_now();
        int off, seg, rom_i, ram_i, is_rom, e_rs, e_as, e_we, e_ra, e_aa;
        string rtag;
        off = int'(win_addr);
        if (off < 'h800) seg = 0; else if (off < 'hE00) seg = 1;     // R1
        else if (off < 'hF00) seg = 2; else seg = 3;
        case (seg)
            0: begin rom_i = int'(lo_slice) * 'h800 + (off % 'h800);            // R3
                     ram_i = (int'(lo_slice) % 16) * 'h800 + (off % 'h800);
                     is_rom = int'(lo_is_rom); rtag = "R3"; end
            1: begin rom_i = 'h10000 + int'(mid_slice) * 'h800 + (off % 'h800); // R4
                     ram_i = (int'(mid_slice) % 16) * 'h800 + (off % 'h800);
                     is_rom = int'(mid_is_rom); rtag = "R4"; end
            2: begin rom_i = 'h10000 + int'(hi_page) * 'h100 + (off % 'h100);   // R5
                     ram_i = (int'(hi_page) % 128) * 'h100 + (off % 'h100);
                     is_rom = int'(hi_is_rom); rtag = "R5"; end
            default: begin rom_i = 'h1FF00 + (off % 'h100); ram_i = 0;          // R2
                     is_rom = 1; rtag = "R2"; end
        endcase
        e_rs = (acc_en && !acc_wr && is_rom != 0) ? 1 : 0;                      // R7
        e_as = (acc_en && is_rom == 0) ? 1 : 0;
        e_we = (e_as != 0 && acc_wr) ? 1 : 0;
        e_ra = (e_rs != 0) ? rom_i : 0;                                         // R9
        e_aa = (e_as != 0) ? ram_i : 0;                                         // R6
        if (!acc_en) rtag = "R8";
        cmp(acc_en ? "R7" : "R8", "rom_sel", int'(rom_sel), e_rs);
        cmp(acc_en ? "R7" : "R8", "ram_sel", int'(ram_sel), e_as);
        cmp(acc_en ? "R7" : "R8", "ram_we",  int'(ram_we),  e_we);
        cmp(rtag, "rom_addr", int'(rom_addr), e_ra);
        cmp(seg == 3 ? "R2" : "R6", "ram_addr", int'(ram_addr), e_aa);
        cmp("R10", "rom_addr folded", int'(rom_addr_s), e_ra % 'h8000);
        cmp("R10", "rom_sel folded",  int'(rom_sel_s),  e_rs);
    endtask

    // One cycle: drive just after the rising edge, compare at the falling edge (R11).
    task automatic step(input bit en, input bit wr, input int a);
        @(posedge clk);
        #1;
        acc_en = en; acc_wr = wr; win_addr = 12'(a);
        @(negedge clk);
        check_now();
    endtask

    task automatic set_modes(input bit lr, input bit mr, input bit hr);
        lo_is_rom = lr; mid_is_rom = mr; hi_is_rom = hr;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // Stimulus: idle state, page boundaries in both modes, then random traffic.
    initial begin
        int bounds [8] = '{'h000, 'h7FF, 'h800, 'hDFF, 'hE00, 'hEFF, 'hF00, 'hFFF};
        acc_en = 1'b0; acc_wr = 1'b0; win_addr = '0;
        lo_slice = 5'h1B; mid_slice = 5'h16; hi_page = 8'hB5;
        set_modes(1'b1, 1'b1, 1'b1);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_now();   // R8 idle state after start
        for (int m = 0; m < 2; m++) begin
            set_modes(m == 0, m == 0, m == 0);
            for (int w = 0; w < 2; w++) begin
                for (int b = 0; b < 8; b++) begin
                    step(1'b1, w != 0, bounds[b]);   // R1 boundaries
                end
            end
        end
        for (int b = 0; b < 8; b++) step(1'b0, 1'b0, bounds[b]);  // R8
        for (int i = 0; i < 4000; i++) begin
            lo_slice  = 5'($urandom);
            mid_slice = 5'($urandom);
            hi_page   = 8'($urandom);
            set_modes(1'($urandom), 1'($urandom), 1'($urandom));
            step(($urandom % 8) != 0, 1'($urandom), int'($urandom % 4096));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule